// File: doc/BRIEF.md
# 16-bit Hamming SEC-DED Controller

This block protects a 16-bit memory data path with a 6-bit check word. On the write side it works out the check word from the data word, so the two can be stored together. On the read side it takes the 22-bit stored word and computes a 6-bit syndrome from it. It classifies the result as no error, a correctable single error or an uncorrectable error. A single flipped data bit is repaired on the output. A flipped check bit is reported, but the data passes through untouched.

The controller is driven by a two-bit mode input:

| Mode | Name | Action |
|------|------|--------|
| 00 | generate | Computes the check word for the data input. |
| 01 | capture | Loads the read data and check bits into internal latches. |
| 10 | flag | Updates the two error flags from the latched word. |
| 11 | correct | Updates the flags the same way, and also drives the corrected data and the syndrome. |

The syndrome identifies the failing bit position. This holds for data-bit and check-bit errors alike.

Top module: `hm_secded_ctrl`

## Requirements
- R1: In mode 00, `chk_o` is the check word of `data_i` and `data_o` equals `data_i`. Check bit j is the XOR of every data bit i whose column has bit j set. The columns of data bits 0..15 are the 16 smallest 6-bit values with exactly three ones, in ascending order (bit 0 gets 0x07, bit 1 gets 0x0B). The column of check bit j is 1<<j.
- R2: At a rising clock edge in mode 01, `data_i` and `chk_i` are loaded into the latches. In every other mode the latches hold their value.
- R3: The flags are updated from the latched word only at a rising edge in mode 10 or 11. In modes 00 and 01 they hold.
- R4: When the syndrome is zero, both flags are updated to 0.
- R5: When the syndrome equals the column of a data bit, `sec_err_o`=1 and `ded_err_o`=0. In mode 11, `data_o` is the latched data with that bit inverted.
- R6: When the syndrome has exactly one bit set (a check-bit error), `sec_err_o`=1 and `ded_err_o`=0. In mode 11, `data_o` equals the latched data.
- R7: In mode 11, `chk_o` carries the syndrome. The syndrome is the check word recomputed from the latched data, XORed with the latched check bits.
- R8: A nonzero syndrome that matches no column sets `ded_err_o`=1 and `sec_err_o`=0, and `data_o` stays uncorrected in mode 11.
- R9: After reset, the latches hold zero and both flags are 0.
- R10: In modes 01 and 10, `data_o` equals the latched data and `chk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operation select |
| data_i | input | 16 | Write data, or read data to capture |
| chk_i | input | 6 | Stored check bits to capture |
| data_o | output | 16 | Pass-through, latched or corrected data |
| chk_o | output | 6 | Generated check word or syndrome |
| sec_err_o | output | 1 | Single (correctable) error flag |
| ded_err_o | output | 1 | Double (uncorrectable) error flag |

## Verification
The bench injects a single flipped bit at each of the 22 positions. It also injects pairs of flips across data–data, data–check and check–check positions, all on random and boundary data words.

- A design with a wrong column map would show the wrong check word or the wrong syndrome.
- A design that corrected check-bit errors would alter the data.
- A design that treated even-weight syndromes as single errors would repair the wrong bit and raise the wrong flag.

The bench also changes the inputs during mode 10 and watches the flags across the capture cycle. A design whose latches or flags move outside their modes would then show stale or early values.

// File: rtl/hm_secded_pkg.sv
package hm_secded_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CHK_W  = 6;

  typedef enum logic [1:0] {
    MODE_GEN   = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_FLAG  = 2'b10,
    MODE_CORR  = 2'b11
  } mode_e;

  // idx-th smallest w-bit value with exactly three ones
  function automatic int unsigned col_code(int unsigned idx, int unsigned w);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned v = 0; v < (32'd1 << w); v++) begin
      int unsigned ones;
      ones = 0;
      for (int unsigned b = 0; b < w; b++) ones += (v >> b) & 32'd1;
      if (ones == 3) begin
        if (cnt == idx) res = v;
        cnt++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/hm_parity_gen.sv
module hm_parity_gen #(
  parameter int unsigned DATA_W = hm_secded_pkg::DATA_W,
  parameter int unsigned CHK_W  = hm_secded_pkg::CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    logic [DATA_W-1:0] mask;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam int unsigned COL = hm_secded_pkg::col_code(i, CHK_W);
      assign mask[i] = COL[j];
    end
    assign chk_o[j] = ^(data_i & mask);
  end
endmodule

// File: rtl/hm_syndrome_dec.sv
module hm_syndrome_dec #(
  parameter int unsigned DATA_W = hm_secded_pkg::DATA_W,
  parameter int unsigned CHK_W  = hm_secded_pkg::CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [CHK_W-1:0]  syn_o,
  output logic              single_o,
  output logic              double_o,
  output logic [DATA_W-1:0] corr_o
);
  logic [CHK_W-1:0]  recomp;
  logic [DATA_W-1:0] hit;
  logic              chk_bit_err;

  hm_parity_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_regen (
    .data_i(data_i),
    .chk_o (recomp)
  );

  assign syn_o = recomp ^ chk_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    localparam int unsigned COL = hm_secded_pkg::col_code(i, CHK_W);
    assign hit[i] = (syn_o == COL[CHK_W-1:0]);
  end

  assign chk_bit_err = (syn_o != '0) && ((syn_o & (syn_o - 1'b1)) == '0);
  assign single_o    = chk_bit_err || (|hit);
  assign double_o    = (syn_o != '0) && !single_o;
  assign corr_o      = data_i ^ hit;
endmodule

// File: rtl/hm_secded_ctrl.sv
module hm_secded_ctrl #(
  parameter int unsigned DATA_W = hm_secded_pkg::DATA_W,
  parameter int unsigned CHK_W  = hm_secded_pkg::CHK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o,
  output logic              sec_err_o,
  output logic              ded_err_o
);
  import hm_secded_pkg::*;

  mode_e             mode;
  logic [DATA_W-1:0] data_q;
  logic [CHK_W-1:0]  chk_q;
  logic [CHK_W-1:0]  gen_chk;
  logic [CHK_W-1:0]  syn;
  logic              single_err;
  logic              double_err;
  logic [DATA_W-1:0] corr_data;

  assign mode = mode_e'(mode_i);

  hm_parity_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_gen (
    .data_i(data_i),
    .chk_o (gen_chk)
  );

  hm_syndrome_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_dec (
    .data_i  (data_q),
    .chk_i   (chk_q),
    .syn_o   (syn),
    .single_o(single_err),
    .double_o(double_err),
    .corr_o  (corr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      chk_q  <= '0;
    end else if (mode == MODE_LATCH) begin
      data_q <= data_i;
      chk_q  <= chk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_err_o <= 1'b0;
      ded_err_o <= 1'b0;
    end else if (mode == MODE_FLAG || mode == MODE_CORR) begin
      sec_err_o <= single_err;
      ded_err_o <= double_err;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_GEN:  begin data_o = data_i;    chk_o = gen_chk; end
      MODE_CORR: begin data_o = corr_data; chk_o = syn;     end
      default:   begin data_o = data_q;    chk_o = '0;      end
    endcase
  end

  p_latch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b01) |=> $stable(data_q) && $stable(chk_q));

  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] == 1'b0) |=> $stable(sec_err_o) && $stable(ded_err_o));

  p_zero_syn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && syn == '0) |=> !sec_err_o && !ded_err_o);

  p_one_fix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && single_err && $countones(syn) == 3)
      |-> $countones(data_o ^ data_q) == 1);

  p_chk_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && $countones(syn) == 1) |-> data_o == data_q);

  p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_err_o && ded_err_o));

  p_ded_raw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && double_err) |-> data_o == data_q);
endmodule

// File: tb/test_hm_secded_ctrl.sv
module test_hm_secded_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] din = '0;
  logic [5:0]  cin = '0;
  logic [15:0] dout;
  logic [5:0]  cout;
  logic        sec, ded;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  logic exp_sec = 0, exp_ded = 0;

  hm_secded_ctrl i_hm_secded_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .data_i(din), .chk_i(cin),
    .data_o(dout), .chk_o(cout), .sec_err_o(sec), .ded_err_o(ded)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] ref_col(int idx);
    int n = 0;
    logic [5:0] r = '0;
    for (int v = 0; v < 64; v++) begin
      if ($countones(v[5:0]) == 3) begin
        if (n == idx) r = v[5:0];
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [5:0] ref_chk(logic [15:0] d);
    logic [5:0] c = '0;
    for (int i = 0; i < 16; i++) if (d[i]) c ^= ref_col(i);
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [15:0] d, logic [15:0] dflip, logic [5:0] cflip);
    logic [5:0]  c;
    logic [15:0] sd;
    logic [5:0]  sc, syn;
    logic [15:0] exp_data;
    int          pos;
    c  = ref_chk(d);
    sd = d ^ dflip;
    sc = c ^ cflip;
    // generate
    @(negedge clk); mode = 2'b00; din = d; #1;
    check("R1 chk", 32'(cout), 32'(c));
    check("R1 data", 32'(dout), 32'(d));
    // capture
    @(negedge clk); mode = 2'b01; din = sd; cin = sc;
    @(negedge clk); #1;
    check("R3 hold sec", 32'(sec), 32'(exp_sec));
    check("R3 hold ded", 32'(ded), 32'(exp_ded));
    check("R2 latched", 32'(dout), 32'(sd));
    check("R10 chk zero", 32'(cout), 32'd0);
    mode = 2'b10; din = ~sd; cin = ~sc;
    #1;
    check("R2 hold in flag", 32'(dout), 32'(sd));
    // expected classification
    syn = ref_chk(sd) ^ sc;
    pos = -1;
    for (int i = 0; i < 16; i++) if (syn == ref_col(i)) pos = i;
    exp_data = sd;
    if (syn == 0) begin
      exp_sec = 0; exp_ded = 0;
    end else if (pos >= 0) begin
      exp_sec = 1; exp_ded = 0; exp_data[pos] = ~exp_data[pos];
    end else if ($countones(syn) == 1) begin
      exp_sec = 1; exp_ded = 0;
    end else begin
      exp_sec = 0; exp_ded = 1;
    end
    @(negedge clk); mode = 2'b11; #1;
    if (syn == 0) begin
      check("R4 sec", 32'(sec), 32'd0);
      check("R4 ded", 32'(ded), 32'd0);
    end else if (pos >= 0) begin
      check("R5 sec", 32'(sec), 32'd1);
      check("R5 ded", 32'(ded), 32'd0);
    end else if (exp_sec) begin
      check("R6 sec", 32'(sec), 32'd1);
      check("R6 ded", 32'(ded), 32'd0);
    end else begin
      check("R8 sec", 32'(sec), 32'd0);
      check("R8 ded", 32'(ded), 32'd1);
    end
    check(pos >= 0 ? "R5 data" : (exp_ded ? "R8 data" : "R6 data"),
          32'(dout), 32'(exp_data));
    check("R7 syndrome", 32'(cout), 32'(syn));
    if (dflip == 0 && cflip == 0) check("R5 clean data", 32'(dout), 32'(d));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES && !done) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, MAX_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 sec", 32'(sec), 32'd0);
    check("R9 ded", 32'(ded), 32'd0);
    @(negedge clk); mode = 2'b10; #1;
    check("R9 latch data", 32'(dout), 32'd0);
    check("R10 chk zero", 32'(cout), 32'd0);
    check("R1 col0", 32'(ref_col(0)), 32'h07);
    run(16'h0000, 0, 0);
    run(16'hFFFF, 0, 0);
    run(16'hA5C3, 0, 0);
    for (int k = 0; k < 3; k++) begin
      d = 16'($urandom);
      for (int i = 0; i < 16; i++) run(d, 16'(1) << i, 0);
      for (int j = 0; j < 6; j++) run(d, 0, 6'(1) << j);
    end
    for (int k = 0; k < 30; k++) begin
      int a, b;
      d = 16'($urandom);
      a = $urandom_range(0, 21);
      b = $urandom_range(0, 20);
      if (b >= a) b++;
      run(d,
          (a < 16 ? 16'(1) << a : 16'd0) | (b < 16 ? 16'(1) << b : 16'd0),
          (a >= 16 ? 6'(1) << (a - 16) : 6'd0) | (b >= 16 ? 6'(1) << (b - 16) : 6'd0));
    end
    run(16'h8001, 16'h8001, 0);
    run(16'h0000, 0, 6'h21);
    run(16'hFFFF, 16'h0001, 6'h01);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule